// File: doc/BRIEF.md
# Register-Based LIFO Stack with Full/Empty Flags

This block is a last-in first-out store of 64 words kept in flip-flops. A 6-bit pointer always addresses the word on top of the stack. A data register carries each value moving in or out. Two status bits report whether the stack is full or empty. A push or a pop finishes in a single clock.

A push advances the pointer first and then writes into the word the pointer now addresses. A pop first copies the addressed word into the data register and then moves the pointer back. Occupancy is not counted separately. The flags change only when the pointer wraps to zero: a push that lands on zero means full, and a pop that lands on zero means empty. As a result, location 0 is used only by the 64th item.

A request that cannot be served does nothing to the stack and gives a one-cycle error pulse. Such a request is a push while full, a pop while empty, or a push and a pop together.

Top module: `regstack_lifo`

## Requirements
- R1: After reset the pointer is 0, the empty flag is 1, the full flag is 0, the error output is 0 and the data output is 0.
- R2: An accepted push (push alone while not full) makes the pointer one larger modulo 64, stores the input word at that new pointer value, and loads the input word into the data register, all visible after the same clock edge.
- R3: An accepted push clears the empty flag and sets the full flag exactly when the new pointer value is 0. Full and empty are never 1 together.
- R4: An accepted pop (pop alone while not empty) loads the word at the current pointer into the data register and makes the pointer one smaller modulo 64.
- R5: An accepted pop clears the full flag and sets the empty flag exactly when the new pointer value is 0.
- R6: A push while full leaves the pointer, flags, data register and stored words unchanged, and raises the error output for the next cycle.
- R7: A pop while empty leaves the pointer, flags and data register unchanged, and raises the error output for the next cycle.
- R8: A push and a pop in the same cycle are rejected: the state is unchanged and the error output is raised for the next cycle.
- R9: The error output is 1 only in the cycle after a rejected request. A cycle with neither request changes nothing and is followed by error 0.
- R10: Sixty-four pushes followed by sixty-four pops return the words in reverse order of entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| wr_data_i | input | DATA_W | Word to push |
| rd_data_o | output | DATA_W | Data register: last word pushed or popped |
| sp_o | output | ADDR_W | Stack pointer, addresses the top item |
| full_o | output | 1 | Stack holds 64 words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
Some rules are checked by the assertions on every cycle:
- the pointer steps by one in the right direction for each accepted request;
- the flags follow the wrap of the pointer to zero;
- the two flags are never set together;
- rejected requests and conflicting requests freeze the state and raise the error pulse;
- idle cycles are followed by no error.

The stored data can only be shown by the bench's scenarios. This covers the word returned by each pop, the reverse order of a full fill and drain, and the fact that a rejected push leaves the stored words intact. The bench compares these against its own model.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_BAD  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/regstack_req_dec.sv
module regstack_req_dec
  import regstack_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    full_i,
  input  logic    empty_i,
  output stk_op_e op_o,
  output logic    reject_o
);
  always_comb begin
    op_o = STK_IDLE;
    unique case ({push_i, pop_i})
      2'b11:   op_o = STK_BAD;
      2'b10:   op_o = full_i  ? STK_BAD : STK_PUSH;
      2'b01:   op_o = empty_i ? STK_BAD : STK_POP;
      default: op_o = STK_IDLE;
    endcase
  end

  assign reject_o = (op_o == STK_BAD);
endmodule

// File: rtl/regstack_ptr.sv
module regstack_ptr
  import regstack_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] sp_up_o,
  output logic              full_o,
  output logic              empty_o
);
  function automatic logic [ADDR_W-1:0] ptr_up(input logic [ADDR_W-1:0] p);
    return p + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_down(input logic [ADDR_W-1:0] p);
    return p - {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] sp_up;
  logic [ADDR_W-1:0] sp_dn;
  logic              full_q;
  logic              empty_q;

  assign sp_up = ptr_up(sp_q);
  assign sp_dn = ptr_down(sp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      unique case (op_i)
        STK_PUSH: begin
          sp_q    <= sp_up;
          full_q  <= (sp_up == '0);
          empty_q <= 1'b0;
        end
        STK_POP: begin
          sp_q    <= sp_dn;
          empty_q <= (sp_dn == '0);
          full_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign sp_o    = sp_q;
  assign sp_up_o = sp_up;
  assign full_o  = full_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/regstack_store.sv
module regstack_store
  import regstack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] dr_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word_q [DEPTH];
  logic [DATA_W-1:0] dr_q;
  logic              wr_en;

  assign wr_en = (op_i == STK_PUSH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic sel;
    assign sel = wr_en && (wr_addr_i == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (sel) word_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= '0;
    end else begin
      unique case (op_i)
        STK_PUSH: dr_q <= wr_data_i;
        STK_POP:  dr_q <= word_q[rd_addr_i];
        default:  ;
      endcase
    end
  end

  assign dr_o = dr_q;
endmodule

// File: rtl/regstack_lifo.sv
module regstack_lifo
  import regstack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  stk_op_e           op;
  logic              reject;
  logic [ADDR_W-1:0] sp;
  logic [ADDR_W-1:0] sp_up;
  logic              full;
  logic              empty;
  logic              err_q;

  regstack_req_dec u_dec (
    .push_i   (push_i),
    .pop_i    (pop_i),
    .full_i   (full),
    .empty_i  (empty),
    .op_o     (op),
    .reject_o (reject)
  );

  regstack_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .sp_o    (sp),
    .sp_up_o (sp_up),
    .full_o  (full),
    .empty_o (empty)
  );

  regstack_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op),
    .rd_addr_i (sp),
    .wr_addr_i (sp_up),
    .wr_data_i (wr_data_i),
    .dr_o      (rd_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= reject;
  end

  assign sp_o    = sp;
  assign full_o  = full;
  assign empty_o = empty;
  assign err_o   = err_q;
endmodule

// File: rtl/regstack_lifo_chk.sv
module regstack_lifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              err_o
);
  logic push_ok, pop_ok;
  assign push_ok = push_i && !pop_i && !full_o;
  assign pop_ok  = pop_i && !push_i && !empty_o;

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> sp_o == ADDR_W'($past(sp_o) + 1'b1));

  assert_push_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (full_o == (sp_o == '0)) && !empty_o && !err_o);

  assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> sp_o == ADDR_W'($past(sp_o) - 1'b1));

  assert_pop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (empty_o == (sp_o == '0)) && !full_o && !err_o);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> $stable(sp_o) && full_o && $stable(rd_data_o) && err_o);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> $stable(sp_o) && empty_o && $stable(rd_data_o) && err_o);

  assert_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> $stable(sp_o) && $stable(full_o) && $stable(empty_o) && err_o);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> !err_o && $stable(sp_o) && $stable(rd_data_o));
endmodule

bind regstack_lifo regstack_lifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .rd_data_o (rd_data_o),
  .sp_o      (sp_o),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .err_o     (err_o)
);

// File: tb/regstack_lifo_tb.sv
module regstack_lifo_tb;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int NW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [AW-1:0] sp_o;
  logic          full_o, empty_o, err_o;

  always #4 clk = ~clk;

  regstack_lifo #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .sp_o(sp_o),
    .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] m_mem [NW];
  int            m_sp;
  bit            m_full, m_empty, m_err;
  logic [DW-1:0] m_dr;

  function automatic int wrap_up(int p);
    return (p == NW - 1) ? 0 : p + 1;
  endfunction

  function automatic int wrap_down(int p);
    return (p == 0) ? NW - 1 : p - 1;
  endfunction

  task automatic compare(string tag);
    n_chk++;
    if (sp_o !== AW'(m_sp) || full_o !== m_full || empty_o !== m_empty ||
        err_o !== m_err || rd_data_o !== m_dr) begin
      n_bad++;
      $display("FAIL %s: got sp=%0d full=%0b empty=%0b err=%0b dr=%0h, expected sp=%0d full=%0b empty=%0b err=%0b dr=%0h",
               tag, sp_o, full_o, empty_o, err_o, rd_data_o,
               m_sp, m_full, m_empty, m_err, m_dr);
    end
  endtask

  // drives at a falling edge, checks at the next falling edge
  task automatic step(bit pu, bit po, logic [DW-1:0] d);
    string tag;
    push_i = pu; pop_i = po; wr_data_i = d;
    m_err = 1'b0;
    if (pu && po) begin
      m_err = 1'b1; tag = "R8 conflict";
    end else if (pu) begin
      if (m_full) begin
        m_err = 1'b1; tag = "R6 push while full";
      end else begin
        m_sp = wrap_up(m_sp);
        m_mem[m_sp] = d;
        m_dr = d;
        m_full = (m_sp == 0);
        m_empty = 1'b0;
        tag = m_full ? "R3 push reaches full" : "R2 push";
      end
    end else if (po) begin
      if (m_empty) begin
        m_err = 1'b1; tag = "R7 pop while empty";
      end else begin
        m_dr = m_mem[m_sp];
        m_sp = wrap_down(m_sp);
        m_empty = (m_sp == 0);
        m_full = 1'b0;
        tag = m_empty ? "R5 pop reaches empty" : "R4 pop";
      end
    end else begin
      tag = "R9 idle";
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run_all();
    m_sp = 0; m_full = 0; m_empty = 1; m_err = 0; m_dr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset state");

    step(0, 1, 8'h00);           // R7 underflow at start
    step(0, 0, 8'h00);           // R9 pulse ends
    for (int i = 0; i < NW; i++) step(1, 0, DW'(i * 7 + 3));  // R2, R3
    step(1, 0, 8'hEE);           // R6 overflow
    step(0, 0, 8'h00);           // R9
    step(1, 1, 8'h55);           // R8 conflict while full
    // R10: drain in reverse order, rejected push must not have disturbed words
    for (int i = 0; i < NW; i++) step(0, 1, 8'h00);
    step(0, 1, 8'h00);           // R7
    step(1, 0, 8'hA1);
    step(1, 1, 8'h33);           // R8 mid-stack
    step(0, 1, 8'h00);           // R5 back to empty

    void'($urandom(32'd20240611));
    for (int blk = 0; blk < 24; blk++) begin
      int bias = (blk % 3 == 0) ? 85 : ((blk % 3 == 1) ? 15 : 50);
      for (int k = 0; k < 150; k++) begin
        int r = int'($urandom_range(99));
        int c = int'($urandom_range(19));
        bit pu = (r < bias);
        bit po = !pu;
        if (c == 0) begin pu = 1; po = 1; end
        else if (c == 1) begin pu = 0; po = 0; end
        step(pu, po, DW'($urandom));
      end
    end
    step(0, 0, 8'h00);
  endtask

  initial begin
    bit timed_out = 0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule